// File: doc/BRIEF.md
# DRAM Row Refresh Scheduler

This block keeps the contents of a 256-row dynamic memory alive by issuing one row refresh per programmable interval. A free-running interval timer queues a refresh each time it expires. When the access sequencer is not busy, the block runs a row-only strobe cycle. It drives the current row number onto the multiplexed address bus, pulls the row strobe low for a programmed number of clocks, and then holds the strobe high for a programmed recovery time. The column strobe is never touched. The 8-bit row counter steps after every completed refresh and wraps from 255 back to 0, so one full sweep takes 256 intervals. With a 5 MHz clock and a 4 ms retention window, the interval is 78 clocks.

The refresh-busy output tells the access sequencer to hold off new accesses. Refresh cycles are taken between processor accesses. An expiry that arrives while a refresh is still waiting is held in a small saturating backlog. Queued refreshes are then run back to back as soon as the bus is free. All pins are plain control and status levels. The block has no data stream, so it has no valid/ready handshake.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is low and right after it is released, ras_n is 1, refresh_busy is 0 and dram_addr is 0. With access_busy low, the first row strobe (row 0) goes low at the (N+1)-th rising edge after reset is released, where N is the interval count.
- R2: While access_busy stays low and no refresh is queued, ras_n falls exactly every N clocks, where N = interval_cnt. An interval count of 0 behaves as 1.
- R3: Each refresh holds ras_n low for exactly max(ras_low_cnt,1) clocks. It then holds ras_n high with refresh_busy still 1 for exactly max(precharge_cnt,1) clocks. refresh_busy is 1 on every clock that ras_n is 0.
- R4: A refresh cycle begins only on an edge at which access_busy is sampled 0. A queued refresh waits as long as access_busy stays 1.
- R5: While refresh_busy is 1, dram_addr carries the row being refreshed. Rows go 0, 1, 2 and so on, and after 255 the next row is 0. While refresh_busy is 0, dram_addr is 0.
- R6: Refreshes that are queued while access_busy is high run back to back once it falls. Between two of them, ras_n is high for exactly max(precharge_cnt,1) clocks and refresh_busy does not drop.
- R7: The backlog holds at most 2^BKLG_W-1 refreshes (7 by default). Further expirations while it is full are dropped.
- R8: The interval timer keeps running while a refresh is queued or in progress. Over a run with short accesses, the number of refreshes equals the number of elapsed intervals.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| interval_cnt | input | IVL_W | Clocks between refresh requests |
| ras_low_cnt | input | TIME_W | Clocks the row strobe stays low |
| precharge_cnt | input | TIME_W | Recovery clocks after the strobe |
| access_busy | input | 1 | Access sequencer is mid-cycle |
| refresh_busy | output | 1 | Refresh owns the bus; accesses must wait |
| dram_addr | output | ROW_W | Multiplexed address bus (row during refresh) |
| ras_n | output | 1 | Active-low row address strobe |

## Verification
The embedded assertions check on every clock several rules:
- a strobe never begins while the access sequencer was busy;
- the strobe stays low until its count runs out;
- the row counter steps by one at the end of each recovery;
- the backlog never wraps past its ceiling, and a refresh is never started without one queued.

Only the bench scenarios can show the properties that span many cycles. These are the exact interval spacing, the first-refresh latency after reset, and the strobe and recovery widths against the programmed counts. They also include the row wrap after 256 refreshes, the number of refreshes drained from a saturated backlog, and the match between refresh count and elapsed intervals under random access traffic.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;
  typedef enum logic [1:0] {
    RF_IDLE    = 2'd0,
    RF_STROBE  = 2'd1,
    RF_RECOVER = 2'd2
  } rf_state_e;
endpackage

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
  parameter int IVL_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IVL_W-1:0] period,
  output logic             tick
);
  logic [IVL_W-1:0] cnt;
  logic [IVL_W-1:0] limit;

  // a zero period is treated as one clock
  assign limit = (period == '0) ? '0 : period - IVL_W'(1);
  // >= so a shortened period mid-run still expires promptly
  assign tick  = (cnt >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + IVL_W'(1);
  end

  // timer never runs past its expiry while the period is held
  p_cnt_bounded_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(period) |-> (cnt <= limit));
endmodule

// File: rtl/rfsh_backlog.sv
module rfsh_backlog #(
  parameter int BKLG_W = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic take,
  output logic pending
);
  localparam logic [BKLG_W-1:0] CEIL = {BKLG_W{1'b1}};

  logic [BKLG_W-1:0] depth;

  always_ff @(posedge clk) begin
    if (!rst_n) depth <= '0;
    else begin
      unique case ({tick, take})
        2'b10:   if (depth != CEIL) depth <= depth + BKLG_W'(1);
        2'b01:   depth <= depth - BKLG_W'(1);
        default: depth <= depth;
      endcase
    end
  end

  assign pending = (depth != '0);

  p_take_has_work_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> pending);
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (depth == CEIL && tick && !take) |=> (depth == CEIL));
endmodule

// File: rtl/rfsh_cycle_fsm.sv
module rfsh_cycle_fsm
  import dram_rfsh_pkg::*;
#(
  parameter int ROW_W  = 8,
  parameter int TIME_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pending,
  input  logic              access_busy,
  input  logic [TIME_W-1:0] strobe_len,
  input  logic [TIME_W-1:0] recover_len,
  output logic              take,
  output logic              ras_n,
  output logic              busy,
  output logic [ROW_W-1:0]  row_addr
);
  rf_state_e         state;
  logic [TIME_W-1:0] tmr;
  logic [ROW_W-1:0]  row;
  logic [TIME_W-1:0] strobe_ld, recover_ld;
  logic              go, tmr_done;

  assign strobe_ld  = (strobe_len  == '0) ? '0 : strobe_len  - TIME_W'(1);
  assign recover_ld = (recover_len == '0) ? '0 : recover_len - TIME_W'(1);
  assign go         = pending && !access_busy;
  assign tmr_done   = (tmr == '0);
  assign take       = go && ((state == RF_IDLE) ||
                             (state == RF_RECOVER && tmr_done));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= RF_IDLE;
      tmr   <= '0;
      row   <= '0;
    end else begin
      unique case (state)
        RF_IDLE: if (go) begin
          state <= RF_STROBE;
          tmr   <= strobe_ld;
        end
        RF_STROBE: if (tmr_done) begin
          state <= RF_RECOVER;
          tmr   <= recover_ld;
        end else tmr <= tmr - TIME_W'(1);
        RF_RECOVER: if (tmr_done) begin
          row <= row + ROW_W'(1);
          if (go) begin
            state <= RF_STROBE;
            tmr   <= strobe_ld;
          end else state <= RF_IDLE;
        end else tmr <= tmr - TIME_W'(1);
        default: state <= RF_IDLE;
      endcase
    end
  end

  assign ras_n    = (state != RF_STROBE);
  assign busy     = (state != RF_IDLE);
  assign row_addr = busy ? row : '0;

  p_ras_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RF_STROBE && !tmr_done) |=> !ras_n);
  p_start_when_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> $past(!access_busy));
  p_row_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RF_RECOVER && tmr_done) |=> (row == ROW_W'($past(row) + 1'b1)));
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter int ROW_W  = 8,
  parameter int IVL_W  = 16,
  parameter int TIME_W = 6,
  parameter int BKLG_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IVL_W-1:0]  interval_cnt,
  input  logic [TIME_W-1:0] ras_low_cnt,
  input  logic [TIME_W-1:0] precharge_cnt,
  input  logic              access_busy,
  output logic              refresh_busy,
  output logic [ROW_W-1:0]  dram_addr,
  output logic              ras_n
);
  logic tick, take, pending;

  rfsh_interval_timer #(.IVL_W(IVL_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .period(interval_cnt), .tick(tick));

  rfsh_backlog #(.BKLG_W(BKLG_W)) u_backlog (
    .clk(clk), .rst_n(rst_n), .tick(tick), .take(take), .pending(pending));

  rfsh_cycle_fsm #(.ROW_W(ROW_W), .TIME_W(TIME_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .pending(pending), .access_busy(access_busy),
    .strobe_len(ras_low_cnt), .recover_len(precharge_cnt), .take(take),
    .ras_n(ras_n), .busy(refresh_busy), .row_addr(dram_addr));

  p_busy_covers_ras_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> refresh_busy);
endmodule

// File: tb/sim_dram_refresh_sched.sv
module sim_dram_refresh_sched;
  localparam int ROW_W = 8, IVL_W = 16, TIME_W = 6, BKLG_W = 3;

  logic clk = 0, rst_n = 0, access_busy = 0;
  logic [IVL_W-1:0]  interval_cnt = 16'd20;
  logic [TIME_W-1:0] ras_low_cnt = 6'd3, precharge_cnt = 6'd2;
  logic refresh_busy, ras_n;
  logic [ROW_W-1:0] dram_addr;

  always #2 clk = ~clk;

  dram_refresh_sched #(.ROW_W(ROW_W), .IVL_W(IVL_W), .TIME_W(TIME_W), .BKLG_W(BKLG_W)) u0 (
    .clk(clk), .rst_n(rst_n), .interval_cnt(interval_cnt), .ras_low_cnt(ras_low_cnt),
    .precharge_cnt(precharge_cnt), .access_busy(access_busy),
    .refresh_busy(refresh_busy), .dram_addr(dram_addr), .ras_n(ras_n));

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int at_least1(int v);
    return (v < 1) ? 1 : v;
  endfunction

  // refreshes completed-or-started by cycle c with no blocking access
  function automatic int exp_falls(int c, int n);
    return (c < n + 1) ? 0 : (c - 1) / n;
  endfunction

  // monitor state
  int cyc, n_falls, low_run, rec_run, first_fall, last_fall, wrap_addr;
  bit prev_ras, prev_busy, spacing_on, first_on;
  logic [ROW_W-1:0] exp_row;

  always @(negedge clk) begin
    if (!rst_n) begin
      cyc = 0; n_falls = 0; low_run = 0; rec_run = 0; exp_row = '0;
      first_fall = -1; last_fall = -1; wrap_addr = -1;
      prev_ras = 1; prev_busy = 0;
    end else begin
      cyc++;
      if (!ras_n && prev_ras) begin
        n_falls++;
        chk(access_busy == 0, "R4 start with access idle", int'(access_busy), 0);
        chk(dram_addr == exp_row, "R5 row address", int'(dram_addr), int'(exp_row));
        if (n_falls == 257) wrap_addr = int'(dram_addr);
        if (prev_busy)
          chk(rec_run == at_least1(int'(precharge_cnt)), "R6 back-to-back gap",
              rec_run, at_least1(int'(precharge_cnt)));
        if (first_on && n_falls == 1)
          chk(cyc == at_least1(int'(interval_cnt)) + 1, "R1 first refresh latency",
              cyc, at_least1(int'(interval_cnt)) + 1);
        if (spacing_on && n_falls > 1)
          chk(cyc - last_fall == at_least1(int'(interval_cnt)), "R2 interval spacing",
              cyc - last_fall, at_least1(int'(interval_cnt)));
        if (n_falls == 1) first_fall = cyc;
        last_fall = cyc;
        exp_row = exp_row + 1'b1;
        low_run = 1;
      end else if (!ras_n) begin
        low_run++;
      end else if (!prev_ras) begin
        chk(low_run == at_least1(int'(ras_low_cnt)), "R3 strobe width",
            low_run, at_least1(int'(ras_low_cnt)));
        rec_run = 1;
      end else if (refresh_busy) begin
        rec_run++;
      end
      if (prev_busy && !refresh_busy)
        chk(rec_run == at_least1(int'(precharge_cnt)), "R3 recovery width",
            rec_run, at_least1(int'(precharge_cnt)));
      if (!ras_n && !refresh_busy)
        chk(0, "R3 busy during strobe", 0, 1);
      if (!refresh_busy && dram_addr != '0)
        chk(0, "R5 idle address zero", int'(dram_addr), 0);
      prev_ras = ras_n;
      prev_busy = refresh_busy;
    end
  end

  task automatic tick_to(int c);
    while (cyc < c) begin @(negedge clk); #1; end
  endtask

  task automatic do_reset(int n, int l, int p, bit busy_hold);
    @(negedge clk); #1;
    rst_n = 0; access_busy = busy_hold;
    interval_cnt = IVL_W'(n); ras_low_cnt = TIME_W'(l); precharge_cnt = TIME_W'(p);
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk(ras_n == 1, "R1 reset ras_n", int'(ras_n), 1);
    chk(refresh_busy == 0, "R1 reset busy", int'(refresh_busy), 0);
    chk(dram_addr == 0, "R1 reset addr", int'(dram_addr), 0);
    rst_n = 1;
  endtask

  initial begin
    int seed;
    int stop_at;
    seed = 32'h5eed_0042;
    void'($urandom(seed));

    // A: idle bus, regular spacing and first latency (R1 R2 R3 R5)
    spacing_on = 1; first_on = 1;
    do_reset(20, 3, 2, 0);
    tick_to(410);
    chk(n_falls == exp_falls(410, 20), "R2 refresh count idle", n_falls, exp_falls(410, 20));

    // B: zero lengths treated as one clock
    do_reset(5, 0, 0, 0);
    tick_to(100);
    chk(n_falls == exp_falls(100, 5), "R2 short interval count", n_falls, exp_falls(100, 5));

    // C: row counter wrap (R5)
    first_on = 0;
    do_reset(8, 2, 1, 0);
    tick_to(8 * 258 + 4);
    chk(wrap_addr == 0, "R5 row wraps to 0", wrap_addr, 0);

    // D: saturated backlog drained back to back (R6 R7 R4)
    spacing_on = 0;
    do_reset(100, 3, 2, 1);
    tick_to(1050);
    chk(n_falls == 0, "R4 waits while busy", n_falls, 0);
    access_busy = 0;
    tick_to(1095);
    chk(n_falls == 7, "R7 backlog ceiling", n_falls, 7);
    chk(last_fall - first_fall == 6 * 5, "R6 back-to-back span", last_fall - first_fall, 30);
    chk(first_fall == 1051, "R4 start after release", first_fall, 1051);

    // E: random access traffic, refresh count tracks intervals (R8 R4)
    do_reset(20, 3, 2, 0);
    while (cyc < 4000) begin
      if (!refresh_busy && ($urandom % 3) != 0) begin
        access_busy = 1;
        repeat (1 + $urandom % 8) begin @(negedge clk); #1; end
        access_busy = 0;
      end
      repeat ($urandom % 11) begin @(negedge clk); #1; end
      @(negedge clk); #1;
    end
    access_busy = 0;
    stop_at = cyc + 60;
    stop_at = stop_at - (stop_at % 20) + 30;
    tick_to(stop_at);
    chk(n_falls == stop_at / 20, "R8 refreshes match intervals", n_falls, stop_at / 20);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule